// File: doc/BRIEF.md
# Center-Aligned Dual-Output PWM Generator

A single-clock pulse-width modulator with two outputs, A and B, driven from one up/down counter that runs in triangle fashion. Each output inverts when the counter reaches that output's compare value. Because the counter climbs and then descends, a compare value inside the ramp produces two inversions per cycle, placed symmetrically about the peak. The resulting pulses are centred on the peak, and several such blocks running the same period stay phase-aligned.

The three compare values (A, B and period) are written into shadow registers at any time. An update strobe marks the shadow set as pending. The pending set becomes the active set at the next cycle start, so one cycle never mixes old and new values. A run input selects between two modes, Stopped and Started. When Started is entered, the outputs take programmed start levels. While Stopped, they hold programmed stop levels. A stop request waits until the current triangle cycle has finished. A two-bit protection stage removes the case where A and B are both high, and it registers the outputs.

Top module: `pwm_center_dual`

## Requirements
- R1: While `rst_n` is low, `pwm_a` and `pwm_b` are 0. Reset leaves the block Stopped, with the active compare values at 0 and no update pending.
- R2: While Stopped, the counter holds at 0. Each output drives its stop level (`lvl_stop_a`, `lvl_stop_b`), which is sampled on every clock.
- R3: At the first clock where `run` is 1 while Stopped, the block enters Started. The counter loads 0, each output takes its start level (`lvl_start_a`, `lvl_start_b`), and a pending shadow set becomes the active set.
- R4: In Started, with active period value P, the counter steps 0, 1, …, P+1, then P, …, 1. It then returns to 0, which begins the next cycle. A cycle therefore lasts 2·(P+1) clocks. P is at most 2^CNT_W − 2.
- R5: An output inverts on the clock after the counter equals that output's active compare value C. The count of inversions per cycle follows from C:
  - two inversions when 1 ≤ C ≤ P;
  - one inversion when C = 0 or C = P+1;
  - no inversion when C > P+1.
- R6: If `run` drops in mid-cycle, the outputs keep toggling until the cycle ends. At the clock where the counter would return to 0, the block becomes Stopped and the outputs take their stop levels.
- R7: A shadow write (`wr_a`, `wr_b` or `wr_per`, each with `wr_data`) has no effect on the outputs until an update strobe has been given and a cycle start has followed it.
- R8: `upd` sets a pending flag. The flag stays set until the next cycle start, where it loads the active set from the shadows as they stand before that clock, and then clears. An `upd` that lands on a cycle-start clock is applied at the following cycle start.
- R9: The protection mode `prot_mode` acts only when A and B are both high. Its codes are:
  - 0: both outputs pass unchanged;
  - 1: A is forced low;
  - 2: B is forced low;
  - 3: both outputs are forced low.
- R10: The outputs are registered after protection. `pwm_a` and `pwm_b` show the internal levels one clock late, protected with the `prot_mode` value sampled on that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 requests Started, 0 requests Stopped |
| wr_a | input | 1 | Write `wr_data` into the A compare shadow |
| wr_b | input | 1 | Write `wr_data` into the B compare shadow |
| wr_per | input | 1 | Write `wr_data` into the period shadow |
| wr_data | input | CNT_W | Shadow write data |
| upd | input | 1 | Update strobe: marks the shadow set pending |
| lvl_start_a | input | 1 | A level on entering Started |
| lvl_start_b | input | 1 | B level on entering Started |
| lvl_stop_a | input | 1 | A level while Stopped |
| lvl_stop_b | input | 1 | B level while Stopped |
| prot_mode | input | 2 | Overlap protection mode |
| pwm_a | output | 1 | Protected output A |
| pwm_b | output | 1 | Protected output B |

## Verification
Every output effect is due two clock edges after the input or counter state that causes it:
- one edge moves the internal level, for example on a compare match, a start, a stop or a stop-level change;
- the second edge registers that level through the protection stage.

The bench drives inputs and samples outputs on the falling edge. Before each rising edge it predicts the output from its own requirement-level state (cycle position, expected active set, pending flag and internal levels), advances that state by one edge, and compares after the edge. Cycle-start alignment for the same-clock update case, and the stop in mid-cycle, are placed by the bench's own position counter. This makes the one-cycle deferral and the completion of the cycle land on exact clocks.

// File: rtl/pwm_tri_pkg.sv
// Package: shared types for the center-aligned PWM block.
// Assumes: none.
package pwm_tri_pkg;
    typedef enum logic [1:0] {
        GUARD_OFF       = 2'd0,
        GUARD_DROP_A    = 2'd1,
        GUARD_DROP_B    = 2'd2,
        GUARD_DROP_BOTH = 2'd3
    } guard_mode_e;

    localparam int NUM_CMP = 3;   // A, B, period
    localparam int IDX_A   = 0;
    localparam int IDX_B   = 1;
    localparam int IDX_P   = 2;
endpackage

// File: rtl/pwm_shadow_bank.sv
// Module: shadow and active compare registers with a pending-update flag.
// What it does: keeps shadow copies written at any time. On a cycle start
// with an update pending, it copies the shadows into the active set.
// Assumes: cyc_start is a one-clock pulse from the counter.
module pwm_shadow_bank #(
    parameter int W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [pwm_tri_pkg::NUM_CMP-1:0] wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       upd,
    input  logic                       cyc_start,
    output logic [W-1:0]               act [pwm_tri_pkg::NUM_CMP]
);
    import pwm_tri_pkg::*;

    logic [W-1:0] shd [NUM_CMP];
    logic         pend;

    // Pending flag: set by the strobe, cleared by the cycle start that consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (upd)       pend <= 1'b1;
        else if (cyc_start) pend <= 1'b0;
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_reg
        // Shadow register: written whenever its enable is high.
        always_ff @(posedge clk) begin
            if (!rst_n)        shd[i] <= '0;
            else if (wr_en[i]) shd[i] <= wr_data;
        end

        // Active register: loaded from the shadow on a cycle start with an update pending.
        always_ff @(posedge clk) begin
            if (!rst_n)                shd_dummy_guard: act[i] <= '0;
            else if (cyc_start && pend) act[i] <= shd[i];
        end
    end
endmodule

// File: rtl/pwm_tri_counter.sv
// Module: triangle counter and Started/Stopped control.
// What it does: counts 0..P+1..1 while Started. It flags cycle starts,
// and it flags a stop taken at the end of a cycle.
// Assumes: act_p <= 2**W - 2, so the peak P+1 does not wrap.
module pwm_tri_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] act_p,
    output logic [W-1:0] cnt,
    output logic         running,
    output logic         cyc_start,
    output logic         stop_now
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         up;
    logic         last;
    logic [W-1:0] peak;

    // Peak value and last-state detection for the current cycle.
    always_comb begin
        peak      = act_p + ONE;
        last      = (cnt == ONE) && (!up || (act_p == '0));
        cyc_start = run && (!running || last);
        stop_now  = running && last && !run;
    end

    // Counter, direction and mode state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            up      <= 1'b1;
        end else if (!running) begin
            running <= run;
            cnt     <= '0;
            up      <= 1'b1;
        end else if (last) begin
            running <= run;
            cnt     <= '0;
            up      <= 1'b1;
        end else if (up && (cnt == peak)) begin
            up  <= 1'b0;
            cnt <= cnt - ONE;
        end else begin
            cnt <= up ? cnt + ONE : cnt - ONE;
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= act_p + ONE));
    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (cnt == '0));
    // R6
    stop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (cnt != ONE)) |=> running);
endmodule

// File: rtl/pwm_chan_out.sv
// Module: internal level of one PWM output, before protection.
// What it does: loads the start level on entering Started and holds the stop
// level while Stopped. Otherwise it inverts on a compare match.
// Assumes: enter and stop_now are single-clock pulses from the counter.
module pwm_chan_out (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic enter,
    input  logic stop_now,
    input  logic match,
    input  logic lvl_start,
    input  logic lvl_stop,
    output logic level
);
    // Level update: start load, stop level, or invert on match.
    always_ff @(posedge clk) begin
        if (!rst_n)                    level <= 1'b0;
        else if (enter)                level <= lvl_start;
        else if (!running || stop_now) level <= lvl_stop;
        else                           level <= level ^ match;
    end
endmodule

// File: rtl/pwm_guard.sv
// Module: overlap protection with registered outputs.
// What it does: when both inputs are high, it clears A, B or both as the
// mode selects, and registers the result.
// Assumes: mode may change on any clock.
module pwm_guard (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_a,
    input  logic       in_b,
    input  logic [1:0] mode,
    output logic       out_a,
    output logic       out_b
);
    import pwm_tri_pkg::*;

    guard_mode_e gm;
    logic        both, nxt_a, nxt_b;

    // Protected next values.
    always_comb begin
        gm    = guard_mode_e'(mode);
        both  = in_a && in_b;
        nxt_a = in_a;
        nxt_b = in_b;
        if (both) begin
            unique case (gm)
                GUARD_OFF:       ;
                GUARD_DROP_A:    nxt_a = 1'b0;
                GUARD_DROP_B:    nxt_b = 1'b0;
                GUARD_DROP_BOTH: begin nxt_a = 1'b0; nxt_b = 1'b0; end
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a <= 1'b0;
            out_b <= 1'b0;
        end else begin
            out_a <= nxt_a;
            out_b <= nxt_b;
        end
    end

    // R9
    both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd3) |-> !(out_a && out_b));
    // R9
    drop_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode) == 2'd1) && $past(in_a && in_b)) |-> (!out_a && out_b));
    // R10
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd0) |-> ((out_a == $past(in_a)) && (out_b == $past(in_b))));
endmodule

// File: rtl/pwm_center_dual.sv
// Module: center-aligned dual-output PWM generator (top).
// What it does: wires together the shadow bank, the triangle counter, two
// output channels and the protection stage.
// Assumes: a single clock; all inputs are synchronous to it.
module pwm_center_dual #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic             wr_per,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             upd,
    input  logic             lvl_start_a,
    input  logic             lvl_start_b,
    input  logic             lvl_stop_a,
    input  logic             lvl_stop_b,
    input  logic [1:0]       prot_mode,
    output logic             pwm_a,
    output logic             pwm_b
);
    import pwm_tri_pkg::*;

    localparam int NCH = 2;

    logic [CNT_W-1:0] act [NUM_CMP];
    logic [CNT_W-1:0] cnt;
    logic             running, cyc_start, stop_now, enter;
    logic [NCH-1:0]   lvl_st, lvl_sp, level;

    // Start pulse from the Stopped mode.
    always_comb begin
        enter  = cyc_start && !running;
        lvl_st = {lvl_start_b, lvl_start_a};
        lvl_sp = {lvl_stop_b, lvl_stop_a};
    end

    pwm_shadow_bank #(.W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     ({wr_per, wr_b, wr_a}),
        .wr_data   (wr_data),
        .upd       (upd),
        .cyc_start (cyc_start),
        .act       (act)
    );

    pwm_tri_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .act_p     (act[IDX_P]),
        .cnt       (cnt),
        .running   (running),
        .cyc_start (cyc_start),
        .stop_now  (stop_now)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_chan_out u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .running   (running),
            .enter     (enter),
            .stop_now  (stop_now),
            .match     (cnt == act[c]),
            .lvl_start (lvl_st[c]),
            .lvl_stop  (lvl_sp[c]),
            .level     (level[c])
        );
    end

    pwm_guard u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .in_a  (level[0]),
        .in_b  (level[1]),
        .mode  (prot_mode),
        .out_a (pwm_a),
        .out_b (pwm_b)
    );

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(act[IDX_A]) && $stable(act[IDX_B]) && $stable(act[IDX_P]));
    // R3
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (cnt == '0));
endmodule

// File: tb/tb_pwm_center_dual.sv
// Bench: directed scenarios. One task per scenario; each task checks its own results.
module tb_pwm_center_dual;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0, wr_a = 1'b0, wr_b = 1'b0, wr_per = 1'b0, upd = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic          lvl_start_a = 1'b0, lvl_start_b = 1'b0;
    logic          lvl_stop_a = 1'b0, lvl_stop_b = 1'b0;
    logic [1:0]    prot_mode = 2'd0;
    logic          pwm_a, pwm_b;

    int n_chk = 0, n_bad = 0, n_edges = 0;

    // Requirement-level expectation state.
    bit m_run, m_q, ra, rb;
    int pos, ecA, ecB, eP, shA, shB, shP;

    always #2 clk = ~clk;

    pwm_center_dual #(.CNT_W(CW)) dut (.*);

    always @(posedge clk) begin
        n_edges++;
        if (n_edges > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got %0d edges exp <100000", n_edges);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int tri_val(int p, int per);
        return (p <= per + 1) ? p : 2 * (per + 1) - p;
    endfunction

    function automatic logic [1:0] guard_exp(bit a, bit b, logic [1:0] m);
        if (a && b) begin
            case (m)
                2'd1:    return 2'b10;   // {b, a}
                2'd2:    return 2'b01;
                2'd3:    return 2'b00;
                default: return 2'b11;
            endcase
        end
        return {b, a};
    endfunction

    task automatic load_act();
        ecA = shA; ecB = shB; eP = shP; m_q = 1'b0;
    endtask

    // Advance the expectation by one edge (inputs as driven), then compare.
    task automatic step_chk(string tag);
        logic [1:0] e = guard_exp(ra, rb, prot_mode);
        if (!m_run) begin
            if (run) begin
                m_run = 1'b1; pos = 0; ra = lvl_start_a; rb = lvl_start_b;
                if (m_q) load_act();
            end else begin
                ra = lvl_stop_a; rb = lvl_stop_b;
            end
        end else begin
            int c = tri_val(pos, eP);
            if (c == ecA) ra = !ra;
            if (c == ecB) rb = !rb;
            pos++;
            if (pos == 2 * (eP + 1)) begin
                pos = 0;
                if (!run) begin m_run = 1'b0; ra = lvl_stop_a; rb = lvl_stop_b; end
                else if (m_q) load_act();
            end
        end
        if (upd) m_q = 1'b1;
        if (wr_a) shA = int'(wr_data);
        if (wr_b) shB = int'(wr_data);
        if (wr_per) shP = int'(wr_data);
        @(posedge clk); @(negedge clk);
        n_chk++;
        if ({pwm_b, pwm_a} !== e) begin
            n_bad++;
            $display("FAIL %s: {b,a} got %b%b exp %b%b at edge %0d", tag, pwm_b, pwm_a, e[1], e[0], n_edges);
        end
    endtask

    task automatic steps(int n, string tag);
        for (int i = 0; i < n; i++) step_chk(tag);
    endtask

    task automatic write_sh(int sel, int val, string tag);
        wr_data = CW'(val);
        wr_a = (sel == 0); wr_b = (sel == 1); wr_per = (sel == 2);
        step_chk(tag);
        wr_a = 1'b0; wr_b = 1'b0; wr_per = 1'b0;
    endtask

    task automatic pulse_upd(string tag);
        upd = 1'b1; step_chk(tag); upd = 1'b0;
    endtask

    // R1: outputs low in reset; expectation state cleared at release.
    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); @(negedge clk);
            n_chk++;
            if (pwm_a !== 1'b0 || pwm_b !== 1'b0) begin
                n_bad++;
                $display("FAIL R1: {b,a} got %b%b exp 00", pwm_b, pwm_a);
            end
        end
        rst_n = 1'b1;
        m_run = 0; m_q = 0; ra = 0; rb = 0; pos = 0;
        ecA = 0; ecB = 0; eP = 0; shA = 0; shB = 0; shP = 0;
    endtask

    // R2 and R10: stop levels followed every clock, two edges late.
    task automatic t_stopped();
        lvl_stop_a = 1'b1; lvl_stop_b = 1'b0; steps(3, "R2");
        lvl_stop_a = 1'b0; lvl_stop_b = 1'b1; steps(3, "R10");
    endtask

    // R9: every protection mode with both levels high.
    task automatic t_guard();
        lvl_stop_a = 1'b1; lvl_stop_b = 1'b1;
        for (int m = 0; m < 4; m++) begin
            prot_mode = 2'(m); steps(3, "R9");
        end
        prot_mode = 2'd0; lvl_stop_a = 1'b0; lvl_stop_b = 1'b0; steps(2, "R2");
    endtask

    // R3, R4, R5: start and three triangle cycles, compares inside the ramp.
    task automatic t_start();
        write_sh(0, 2, "R7"); write_sh(1, 4, "R7"); write_sh(2, 5, "R7");
        pulse_upd("R8");
        lvl_start_a = 1'b0; lvl_start_b = 1'b1; run = 1'b1;
        steps(36, "R4");
    endtask

    // R5: compares at 0, at P+1 and beyond the peak.
    task automatic t_edges();
        write_sh(0, 0, "R5"); write_sh(1, 6, "R5"); pulse_upd("R5");
        steps(30, "R5");
        write_sh(1, 9, "R5"); pulse_upd("R5");
        steps(30, "R5");
    endtask

    // R7: write without update has no effect; then the update applies at a boundary.
    task automatic t_shadow();
        write_sh(0, 3, "R7"); write_sh(1, 1, "R7");
        steps(24, "R7");
        pulse_upd("R8");
        steps(24, "R8");
    endtask

    // R8: update landing on the cycle-start clock is deferred one cycle.
    task automatic t_upd_edge();
        write_sh(0, 1, "R8");
        while (pos != 2 * (eP + 1) - 1) step_chk("R8");
        pulse_upd("R8");
        steps(30, "R8");
    endtask

    // R6: stop in mid-cycle completes the cycle.
    task automatic t_stop();
        lvl_stop_a = 1'b1; lvl_stop_b = 1'b0;
        while (pos != 3) step_chk("R6");
        run = 1'b0;
        steps(20, "R6");
    endtask

    // R3 and R9: restart with a new period loaded at the start, protection active.
    task automatic t_restart();
        write_sh(2, 2, "R3"); write_sh(0, 1, "R3"); write_sh(1, 3, "R3");
        pulse_upd("R8");
        prot_mode = 2'd2;
        lvl_start_a = 1'b1; lvl_start_b = 1'b0; run = 1'b1;
        steps(30, "R3");
        prot_mode = 2'd3; steps(12, "R9");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stopped();
        t_guard();
        t_start();
        t_edges();
        t_shadow();
        t_upd_edge();
        t_stop();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule